// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial memory front end. It gathers the data bytes of one write transaction into a page-sized holding buffer and, once the bus stop condition arrives, copies the received bytes into an external storage array through a simple write port. It then holds a busy flag for a programmable number of clock cycles, which stands in for the self-timed programming cycle of a nonvolatile memory. While busy, the block refuses all new bytes.

Data bytes arrive on a valid/ready stream. A byte is taken on a rising clock edge where `byte_valid` and `byte_ready` are both high. `byte_ready` is high whenever the block is not busy, so an upstream byte decoder can use it as the acknowledge for that byte. While `byte_ready` is low, the producer may keep `byte_valid` asserted. Nothing is queued: a byte that is not taken simply does not exist for this block. The stop pulse, the write-protect level and the density code are plain control inputs. The density code selects both the page size and how many address bits are meaningful.

Top module: `pwb_page_commit`

## Requirements
- R1: After reset, `busy` is 0, `byte_ready` is 1 and `mem_we` is 0.
- R2: `byte_ready` is the inverse of `busy`. A byte offered while `busy` is high is not taken, is never written, and leaves no trace in the buffer.
- R3: The first byte taken into an empty buffer sets the page row and the starting slot from `byte_addr`. Each later byte goes to the next slot of that page, and its `byte_addr` is ignored.
- R4: The page holds 8 bytes when `density` is 0 and 16 bytes otherwise. The slot index wraps from the last slot of the page to slot 0 of the same page, and a later byte overwrites the slot it lands on.
- R5: `density` code d (0..3) makes only the low 8+d bits of `byte_addr` meaningful. Higher bits are ignored, so every `mem_addr` has them at zero.
- R6: A `stop_seen` pulse sampled at edge k, with `busy` low, `wr_protect` low and at least one byte buffered, raises `busy` after edge k. `busy` then stays high for exactly WR_CYCLES cycles and falls after edge k+WR_CYCLES.
- R7: During the commit, slot i of the page is presented on the write port (`mem_we` high, `mem_addr` = page row + i, `mem_data` = the byte held in slot i) in the cycle after edge k+i. This happens only for slots that received a byte, so slots are written in ascending slot order.
- R8: If `wr_protect` is high when the stop is sampled, the buffer is discarded, nothing is written and `busy` stays low. Bytes are still taken while `wr_protect` is high.
- R9: A stop with no byte buffered (a dummy write) starts no busy period and writes nothing.
- R10: `stop_seen` while `busy` is high has no effect. It neither extends nor restarts the busy period.
- R11: When the busy period ends, or after a discard, the buffer is empty. The next byte sets a fresh page row and slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Block can take a byte (not busy) |
| byte_addr | input | AW | Target word address, used on the first byte only |
| byte_data | input | DW | Data byte |
| stop_seen | input | 1 | One-cycle pulse: bus stop condition detected |
| wr_protect | input | 1 | High blocks the array update at stop |
| density | input | 2 | Array size code: 0=256, 1=512, 2=1024, 3=2048 words |
| busy | output | 1 | Timed write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | AW | Array write address |
| mem_data | output | DW | Array write data |

## Verification
A byte is stored on the edge where it is taken. The commit has a fixed timing relative to the edge k that samples the stop: `busy` is visible after edge k and clears after edge k+WR_CYCLES, and slot i is written at edge k+1+i. The bench stamps each edge with a cycle counter and records the counter value at the stop edge. It checks each logged write against offset i+1 and checks that `busy` has fallen at offset WR_CYCLES+1. All ports are sampled on the falling clock edge, half a cycle away from any register update.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
  typedef enum logic [1:0] {
    DEN_256 = 2'd0,
    DEN_512 = 2'd1,
    DEN_1K  = 2'd2,
    DEN_2K  = 2'd3
  } den_e;

  // number of meaningful word-address bits for a density code
  function automatic int span_bits(den_e d);
    return 8 + int'(d);
  endfunction
endpackage

// File: rtl/pwb_collect.sv
`timescale 1ns/1ps
module pwb_collect #(
  parameter int AW       = 11,
  parameter int DW       = 8,
  parameter int PAGE_MAX = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [DW-1:0]               data_i,
  input  logic                        clr_i,
  input  logic [AW-1:0]               addr_mask_i,
  input  logic [$clog2(PAGE_MAX)-1:0] idx_mask_i,
  input  logic [$clog2(PAGE_MAX)-1:0] rd_slot_i,
  output logic [DW-1:0]               rd_data_o,
  output logic                        rd_hit_o,
  output logic [AW-1:0]               base_o,
  output logic                        filled_o
);
  localparam int IW = $clog2(PAGE_MAX);

  logic [PAGE_MAX-1:0] hit_q;
  logic [DW-1:0]       slot_q [PAGE_MAX];
  logic [IW-1:0]       idx_q;
  logic [IW-1:0]       wr_slot;
  logic [AW-1:0]       base_q;
  logic                filled_q;

  assign wr_slot = filled_q ? idx_q : (addr_i[IW-1:0] & idx_mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filled_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else if (clr_i) begin
      filled_q <= 1'b0;
    end else if (take_i) begin
      filled_q <= 1'b1;
      idx_q    <= (wr_slot + IW'(1)) & idx_mask_i;
      if (!filled_q)
        base_q <= addr_i & addr_mask_i & ~AW'(idx_mask_i);
    end
  end

  for (genvar g = 0; g < PAGE_MAX; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        hit_q[g] <= 1'b0;
      else if (clr_i)
        hit_q[g] <= 1'b0;
      else if (take_i && wr_slot == IW'(g))
        hit_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (take_i && wr_slot == IW'(g))
        slot_q[g] <= data_i;
    end
  end

  assign rd_data_o = slot_q[rd_slot_i];
  assign rd_hit_o  = hit_q[rd_slot_i];
  assign base_o    = base_q;
  assign filled_o  = filled_q;

  // R2
  hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !clr_i) |=> $stable(hit_q));

  // R4
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !clr_i) |=> ((idx_q & ~$past(idx_mask_i)) == '0));
endmodule

// File: rtl/pwb_seq.sv
`timescale 1ns/1ps
module pwb_seq #(
  parameter int WR_CYCLES = 250000,
  parameter int PAGE_MAX  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go_i,
  input  logic [$clog2(PAGE_MAX):0]   page_len_i,
  output logic                        busy_o,
  output logic                        win_o,
  output logic                        done_o,
  output logic [$clog2(PAGE_MAX)-1:0] slot_o
);
  localparam int IW = $clog2(PAGE_MAX);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(WR_CYCLES - 1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else if (go_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(WR_CYCLES - 1));
  assign win_o  = busy_q && (cnt_q < CW'(page_len_i));
  assign slot_o = cnt_q[IW-1:0];

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(go_i));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_o) |=> busy_q);
endmodule

// File: rtl/pwb_page_commit.sv
`timescale 1ns/1ps
module pwb_page_commit #(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int PAGE_MIN  = 8,
  parameter int PAGE_MAX  = 16,
  parameter int WR_CYCLES = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  output logic          byte_ready,
  input  logic [AW-1:0] byte_addr,
  input  logic [DW-1:0] byte_data,
  input  logic          stop_seen,
  input  logic          wr_protect,
  input  logic [1:0]    density,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  import pwb_pkg::*;

  localparam int IW = $clog2(PAGE_MAX);

  den_e          den;
  logic [AW-1:0] addr_mask;
  logic [IW-1:0] idx_mask;
  logic [IW:0]   page_len;
  logic          take, go, discard, clr, filled, win, done, hit;
  logic [IW-1:0] slot;
  logic [AW-1:0] base;
  logic [DW-1:0] rd_data;

  assign den       = den_e'(density);
  assign addr_mask = ~({AW{1'b1}} << span_bits(den));
  assign idx_mask  = (den == DEN_256) ? IW'(PAGE_MIN - 1) : IW'(PAGE_MAX - 1);
  assign page_len  = {1'b0, idx_mask} + (IW+1)'(1);

  assign byte_ready = !busy;
  assign take       = byte_valid && byte_ready;
  assign go         = stop_seen && !busy && !wr_protect && (filled || take);
  assign discard    = stop_seen && !busy && !go;
  assign clr        = discard || done;

  pwb_collect #(.AW(AW), .DW(DW), .PAGE_MAX(PAGE_MAX)) u_collect (
    .clk(clk), .rst_n(rst_n), .take_i(take), .addr_i(byte_addr),
    .data_i(byte_data), .clr_i(clr), .addr_mask_i(addr_mask),
    .idx_mask_i(idx_mask), .rd_slot_i(slot), .rd_data_o(rd_data),
    .rd_hit_o(hit), .base_o(base), .filled_o(filled)
  );

  pwb_seq #(.WR_CYCLES(WR_CYCLES), .PAGE_MAX(PAGE_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_i(go), .page_len_i(page_len),
    .busy_o(busy), .win_o(win), .done_o(done), .slot_o(slot)
  );

  assign mem_we   = win && hit;
  assign mem_addr = base | AW'(slot);
  assign mem_data = rd_data;

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && wr_protect && !busy) |=> !busy);

  // R9
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !busy && !filled && !byte_valid) |=> !busy);

  // R5
  addr_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr & ~addr_mask) == '0));

  // R7
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
endmodule

// File: tb/pwb_page_commit_tb.sv
`timescale 1ns/1ps
module pwb_page_commit_tb;
  localparam int W = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic        byte_ready;
  logic [10:0] byte_addr = '0;
  logic [7:0]  byte_data = '0;
  logic        stop_seen = 1'b0;
  logic        wr_protect = 1'b0;
  logic [1:0]  density = 2'd3;
  logic        busy, mem_we;
  logic [10:0] mem_addr;
  logic [7:0]  mem_data;

  always #10 clk = ~clk;

  pwb_page_commit #(.WR_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_addr(byte_addr), .byte_data(byte_data), .stop_seen(stop_seen),
    .wr_protect(wr_protect), .density(density), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  int checks = 0, fails = 0;
  int cyc = 0, stop_cyc = 0, n_log = 0, log_base = 0;
  bit done = 0;
  logic [7:0]  shadow [0:2047];
  int          log_a [0:63];
  int          log_c [0:63];

  always @(posedge clk) begin
    if (mem_we) begin
      shadow[mem_addr] = mem_data;
      if (n_log < 64) begin
        log_a[n_log] = int'(mem_addr);
        log_c[n_log] = cyc;
      end
      n_log = n_log + 1;
    end
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    byte_valid = 1'b1; byte_addr = a; byte_data = d;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk);
    stop_seen = 1'b1; stop_cyc = cyc; log_base = n_log;
    @(negedge clk);
    stop_seen = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    // R6: busy falls after edge k+W
    chk(cyc - stop_cyc == W + 1, "R6 busy length", cyc - stop_cyc, W + 1);
  endtask

  task automatic wlog(input int i, input int a, input int off, input string req);
    chk(log_a[log_base+i] == a, req, log_a[log_base+i], a);
    chk(log_c[log_base+i] - stop_cyc == off, "R7 write cycle",
        log_c[log_base+i] - stop_cyc, off);
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R1
    chk(busy == 0 && byte_ready == 1 && mem_we == 0, "R1 reset state",
        {busy, byte_ready, mem_we}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && byte_ready == 1, "R1 after release", {busy, byte_ready}, 2'b01);
  endtask

  task automatic t_partial();
    density = 2'd3;
    put(11'h135, 8'hA0);
    put(11'h7AA, 8'hA1);   // R3: later address ignored
    put(11'h000, 8'hA2);
    stop_pulse();
    chk(busy == 1, "R6 busy after stop", busy, 1);
    drain();
    chk(n_log - log_base == 3, "R7 only received slots", n_log - log_base, 3);
    wlog(0, 'h135, 6, "R3 slot5 addr");
    wlog(1, 'h136, 7, "R3 slot6 addr");
    wlog(2, 'h137, 8, "R3 slot7 addr");
    chk(shadow['h136] == 8'hA1, "R7 data", shadow['h136], 8'hA1);
    chk(shadow['h134] == 8'hEE, "R7 untouched slot", shadow['h134], 8'hEE);
  endtask

  task automatic t_wrap8();
    density = 2'd0;
    for (int k = 0; k < 10; k++) put(k == 0 ? 11'h706 : 11'h3AA, 8'h10 + 8'(k));
    stop_pulse();
    drain();
    chk(n_log - log_base == 8, "R4 8-byte page writes", n_log - log_base, 8);
    for (int j = 0; j < 8; j++) begin
      logic [7:0] e;
      e = (j == 6) ? 8'h18 : (j == 7) ? 8'h19 : 8'h12 + 8'(j);
      chk(shadow[j] == e, "R4 wrap overwrite", shadow[j], e);
      wlog(j, j, j + 1, "R5 high bits dropped");
    end
  endtask

  task automatic t_wrap16();
    density = 2'd1;
    put(11'h7FE, 8'hC1);
    put(11'h001, 8'hC2);
    put(11'h002, 8'hC3);
    stop_pulse();
    drain();
    chk(n_log - log_base == 3, "R4 16-byte wrap count", n_log - log_base, 3);
    wlog(0, 'h1F0, 1, "R4 wrap to slot0");
    wlog(1, 'h1FE, 15, "R5 9-bit span");
    wlog(2, 'h1FF, 16, "R4 last slot");
    chk(shadow['h1F0] == 8'hC3, "R4 wrapped data", shadow['h1F0], 8'hC3);
  endtask

  task automatic t_protect();
    density = 2'd3;
    wr_protect = 1'b1;
    @(negedge clk);
    chk(byte_ready == 1, "R8 bytes taken under protect", byte_ready, 1);
    put(11'h050, 8'h31);
    put(11'h051, 8'h32);
    stop_pulse();
    chk(busy == 0, "R8 no busy", busy, 0);
    repeat (5) @(negedge clk);
    chk(n_log == log_base, "R8 no write", n_log - log_base, 0);
    wr_protect = 1'b0;
    put(11'h060, 8'h77);
    stop_pulse();
    drain();
    chk(n_log - log_base == 1, "R11 discarded buffer", n_log - log_base, 1);
    wlog(0, 'h060, 1, "R11 fresh address");
    chk(shadow['h050] == 8'hEE, "R8 array unchanged", shadow['h050], 8'hEE);
  endtask

  task automatic t_dummy();
    stop_pulse();
    chk(busy == 0, "R9 dummy stop no busy", busy, 0);
    repeat (3) @(negedge clk);
    chk(n_log == log_base && busy == 0, "R9 no write", n_log - log_base, 0);
  endtask

  task automatic t_lockout();
    density = 2'd3;
    put(11'h100, 8'h55);
    stop_pulse();
    chk(byte_ready == 0, "R2 not ready while busy", byte_ready, 0);
    byte_valid = 1'b1; byte_addr = 11'h200; byte_data = 8'h99;
    repeat (3) @(negedge clk);
    stop_seen = 1'b1;   // R10: stop during busy
    @(negedge clk);
    stop_seen = 1'b0;
    repeat (2) @(negedge clk);
    byte_valid = 1'b0;
    drain();
    chk(n_log - log_base == 1, "R10 single commit", n_log - log_base, 1);
    chk(shadow['h200] == 8'hEE, "R2 locked byte not written", shadow['h200], 8'hEE);
    stop_pulse();
    chk(busy == 0, "R2 locked byte not buffered", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) shadow[i] = 8'hEE;
    repeat (3) @(negedge clk);
    t_reset();
    t_partial();
    t_wrap8();
    t_wrap16();
    t_protect();
    t_dummy();
    t_lockout();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule